// File: doc/BRIEF.md
# Period-Match Timer with Capture-Driven Reset and One-Shot Start

This block is a 16-bit time base that advances on a prescaled clock-enable tick and compares its count against a programmable period value. When the count equals the period on an advancing tick, the count returns to zero. In the same clock edge a sticky interrupt flag is set, a one-cycle event-trigger pulse goes out to downstream logic (for example an ADC start), and, if sleep is asserted, a wake request pulse goes out.

A capture input gives external timing control. A rising edge on it clears the time base, unless the control word blocks this. In one-shot mode a capture edge also starts a stopped timer. The following period match then stops the timer again, so the event-trigger pulse fires a programmable delay after the capture edge. Software reaches the count, the period and a control word through a single write port. A sleep input halts counting unless the control word and the external-clock select together allow the timer to keep running.

Top module: `pmt_timer`

## Requirements
- R1: After a synchronous active-low reset the count is 0, the period reads 16'hFFFF, the timer is disabled, the interrupt flag is clear, and neither the event-trigger output nor the wake output is high.
- R2: Write address 0 loads the count, address 1 loads the period, and address 2 loads the control word. On each prescaled step the count increments by one. When a step finds the count equal to the period, the count reloads to 0 instead, and this is a period match.
- R3: Control bits 6:5 select a prescale ratio of 1, 2, 4 or 8 (codes 0 to 3). The prescaler is cleared by a count write, by a capture-driven reset, and while the timer is disabled. The first step therefore comes on the ratio-th tick after the clear.
- R4: The interrupt flag is set in the clock edge of a period match. It stays set until a control write with bit 7 equal to 1 clears it. If a match and a clearing write happen in the same edge, the match wins.
- R5: A period match produces a one-cycle high on the event-trigger output in the same edge as the reload, provided control bit 4 (asynchronous mode) is 0. When that bit is 1, the output stays low.
- R6: The capture input is registered, and its rising transition acts on the second clock edge after the input rises. That edge clears the count and the prescaler in both continuous and one-shot modes, unless control bit 2 (reset block) is 1, in which case the count is unaffected.
- R7: With control bit 1 (one-shot) set and the timer disabled, a capture edge sets the enable bit (control bit 0). With one-shot set, a period match clears the enable bit, and the count then stays at 0.
- R8: A count write in the same edge as a capture-driven reset loads the written value, and the reset is ignored. A control write likewise overrides the hardware changes to the enable bit.
- R9: While sleep is asserted, the timer counts only when enable, control bit 3 (sleep run), control bit 4 (asynchronous mode) and the external-clock select are all 1. Otherwise the count holds.
- R10: A period match while sleep is asserted raises the wake output for one cycle, in the same edge as the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 count, 1 period, 2 control |
| wr_data | input | 16 | Write data |
| tick_en | input | 1 | Timer clock-enable tick, internal or external source |
| ext_clk_sel | input | 1 | High when the tick comes from the external clock |
| sleep_req | input | 1 | Device sleep indication |
| cap_in | input | 1 | Capture edge input |
| count_o | output | 16 | Current count |
| period_o | output | 16 | Period register |
| enable_o | output | 1 | Timer enable bit |
| irq_flag_o | output | 1 | Sticky period-match interrupt flag |
| trig_o | output | 1 | One-cycle event-trigger pulse |
| wake_o | output | 1 | One-cycle wake request on a match during sleep |

## Verification
The count and all flags are registered, so register writes, period matches and flag changes appear one clock edge after the stimulus. A capture edge takes effect two edges after the input rises, because it first passes through a register. With a prescale ratio of N, the first count step comes N ticks after the prescaler clears. The bench drives inputs on the falling edge and samples on the next falling edge. A cycle-accurate reference model is advanced on every rising edge, so every output is compared each cycle. The directed cases wait for exactly the edge count that the latencies above predict before they check absolute values.

// File: rtl/pmt_pkg.sv
// Package: shared types for the period-match timer.
// Assumes a control word whose lower eight bits carry all fields.
package pmt_pkg;

    // Width of the prescale-ratio selector (ratio = 2**code).
    localparam int PSC_SEL_W = 2;

    // Register selector on the write port.
    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_PERIOD = 2'd1,
        REG_CTRL   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    // Stored control fields, packed to match write-data bits 6:1.
    typedef struct packed {
        logic [PSC_SEL_W-1:0] psc_sel;    // bits 6:5
        logic                 async_mode; // bit 4
        logic                 sleep_run;  // bit 3
        logic                 rst_block;  // bit 2
        logic                 one_shot;   // bit 1
    } ctrl_t;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 7;

endpackage

// File: rtl/pmt_edge_detect.sv
// Module: pmt_edge_detect
// Registers an input and flags its rising transition for one cycle.
// Assumes the input is already synchronous to clk.
module pmt_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);

    logic stage_q;
    logic prev_q;

    // Two-stage history of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            stage_q <= sig_i;
            prev_q  <= stage_q;
        end
    end

    // Rising transition of the registered input.
    always_comb rise_o = stage_q & ~prev_q;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R6

endmodule

// File: rtl/pmt_prescaler.sv
// Module: pmt_prescaler
// Divides the clock-enable tick by 2**sel_i and emits a one-cycle step.
// Assumes the caller clears it on reload events and while disabled.
module pmt_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             step_o
);

    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] psc_q;
    logic [CNT_W-1:0] limit;

    // Terminal value: ratio minus one, built as a thermometer code.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            limit[i] = (i < int'(sel_i));
        end
    end

    // Step when the running tick reaches the terminal value.
    always_comb step_o = run_i && tick_i && (psc_q >= limit);

    // Tick counter with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (clear_i || step_o) begin
            psc_q <= '0;
        end else if (run_i && tick_i) begin
            psc_q <= psc_q + 1'b1;
        end
    end

endmodule

// File: rtl/pmt_counter.sv
// Module: pmt_counter
// Time-base counter: load, zero, step with reload at the period value.
// Assumes load and zero are mutually prioritised here (load wins).
module pmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         zero_i,
    input  logic         step_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] count_o,
    output logic         match_o
);

    logic [W-1:0] count_q;

    // Period match: a step that finds the count at the period.
    always_comb match_o = step_i && !load_i && !zero_i && (count_q == period_i);

    // Count update: write, then capture reset, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (zero_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= (count_q == period_i) ? '0 : count_q + 1'b1;
        end
    end

    always_comb count_o = count_q;

    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> (count_q == '0)); // R2

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_q == $past(load_val_i))); // R8

endmodule

// File: rtl/pmt_ctrl_regs.sv
// Module: pmt_ctrl_regs
// Holds the period, control fields, enable bit and interrupt flag.
// Assumes register writes take priority over hardware updates.
module pmt_ctrl_regs
    import pmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl_i,
    input  logic                 wr_period_i,
    input  logic [W-1:0]         wr_data_i,
    input  logic                 cap_rise_i,
    input  logic                 match_i,
    output logic [W-1:0]         period_o,
    output logic [PSC_SEL_W-1:0] psc_sel_o,
    output logic                 async_o,
    output logic                 sleep_run_o,
    output logic                 rst_block_o,
    output logic                 enable_o,
    output logic                 irq_o
);

    logic [W-1:0] period_q;
    ctrl_t        ctrl_q;
    logic         enable_q;
    logic         irq_q;
    logic         clr_req;

    always_comb clr_req = wr_ctrl_i && wr_data_i[CTRL_CLR_BIT];

    // Period register, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '1;
        end else if (wr_period_i) begin
            period_q <= wr_data_i;
        end
    end

    // Control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl_i) begin
            ctrl_q <= ctrl_t'(wr_data_i[$bits(ctrl_t):1]);
        end
    end

    // Enable bit: write, one-shot stop, or one-shot capture start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
        end else if (wr_ctrl_i) begin
            enable_q <= wr_data_i[CTRL_EN_BIT];
        end else if (match_i && ctrl_q.one_shot) begin
            enable_q <= 1'b0;
        end else if (cap_rise_i && ctrl_q.one_shot && !enable_q) begin
            enable_q <= 1'b1;
        end
    end

    // Sticky interrupt flag; a match beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (match_i) begin
            irq_q <= 1'b1;
        end else if (clr_req) begin
            irq_q <= 1'b0;
        end
    end

    always_comb begin
        period_o    = period_q;
        psc_sel_o   = ctrl_q.psc_sel;
        async_o     = ctrl_q.async_mode;
        sleep_run_o = ctrl_q.sleep_run;
        rst_block_o = ctrl_q.rst_block;
        enable_o    = enable_q;
        irq_o       = irq_q;
    end

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (match_i && ctrl_q.one_shot && !wr_ctrl_i) |=> !enable_q); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr_req) |=> irq_q); // R4

endmodule

// File: rtl/pmt_timer.sv
// Module: pmt_timer (top)
// Period-match timer with capture-driven reset, one-shot start,
// event-trigger and wake outputs, and sleep gating.
// Assumes tick_en is already synchronous to clk.
module pmt_timer
    import pmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick_en,
    input  logic             ext_clk_sel,
    input  logic             sleep_req,
    input  logic             cap_in,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] period_o,
    output logic             enable_o,
    output logic             irq_flag_o,
    output logic             trig_o,
    output logic             wake_o
);

    reg_sel_e             sel;
    logic                 wr_count;
    logic                 wr_period;
    logic                 wr_ctrl;
    logic                 cap_rise;
    logic                 trig_rst;
    logic                 keep_in_sleep;
    logic                 run;
    logic                 step;
    logic                 match;
    logic                 psc_clear;
    logic [PSC_SEL_W-1:0] psc_sel;
    logic                 async_mode;
    logic                 sleep_run;
    logic                 rst_block;
    logic                 trig_q;
    logic                 wake_q;

    // Write-port decode.
    always_comb begin
        sel       = reg_sel_e'(wr_addr);
        wr_count  = wr_en && (sel == REG_COUNT);
        wr_period = wr_en && (sel == REG_PERIOD);
        wr_ctrl   = wr_en && (sel == REG_CTRL);
    end

    pmt_edge_detect u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (cap_in),
        .rise_o (cap_rise)
    );

    pmt_ctrl_regs #(.W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl_i   (wr_ctrl),
        .wr_period_i (wr_period),
        .wr_data_i   (wr_data),
        .cap_rise_i  (cap_rise),
        .match_i     (match),
        .period_o    (period_o),
        .psc_sel_o   (psc_sel),
        .async_o     (async_mode),
        .sleep_run_o (sleep_run),
        .rst_block_o (rst_block),
        .enable_o    (enable_o),
        .irq_o       (irq_flag_o)
    );

    // Run gating and capture-driven reset.
    always_comb begin
        trig_rst      = cap_rise && !rst_block;
        keep_in_sleep = sleep_run && ext_clk_sel && async_mode;
        run           = enable_o && (!sleep_req || keep_in_sleep);
        psc_clear     = !enable_o || wr_count || trig_rst;
    end

    pmt_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (psc_clear),
        .run_i   (run),
        .tick_i  (tick_en),
        .sel_i   (psc_sel),
        .step_o  (step)
    );

    pmt_counter #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wr_count),
        .load_val_i (wr_data),
        .zero_i     (trig_rst),
        .step_i     (step),
        .period_i   (period_o),
        .count_o    (count_o),
        .match_o    (match)
    );

    // Registered event-trigger and wake pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            trig_q <= match && !async_mode;
            wake_q <= match && sleep_req;
        end
    end

    always_comb begin
        trig_o = trig_q;
        wake_o = wake_q;
    end

    AST_TRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> irq_flag_o); // R5

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req && !keep_in_sleep && !wr_count && !trig_rst) |=> $stable(count_o)); // R9

    AST_WAKE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(sleep_req)); // R10

endmodule

// File: tb/pmt_timer_test.sv
`timescale 1ns/1ps
module pmt_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        tick_en = 1'b0;
    logic        ext_clk_sel = 1'b0;
    logic        sleep_req = 1'b0;
    logic        cap_in = 1'b0;
    logic [15:0] count_o, period_o;
    logic        enable_o, irq_flag_o, trig_o, wake_o;

    int nchk = 0;
    int nfail = 0;
    int cyc_n = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    pmt_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick_en(tick_en), .ext_clk_sel(ext_clk_sel),
        .sleep_req(sleep_req), .cap_in(cap_in), .count_o(count_o),
        .period_o(period_o), .enable_o(enable_o), .irq_flag_o(irq_flag_o),
        .trig_o(trig_o), .wake_o(wake_o)
    );

    // Reference model state, built from the requirements.
    logic [15:0] m_cnt, m_per;
    logic [2:0]  m_psc;
    logic [1:0]  m_ps;
    logic m_en, m_ss, m_rb, m_sr, m_as, m_irq, m_trig, m_wake, m_c1, m_c2;

    function automatic bit ratio_done(input logic [2:0] psc, input logic [1:0] code);
        return int'(psc) >= ((1 << code) - 1); // R3
    endfunction

    function automatic bit sleep_allows(input logic en, sr, as_m, ext, slp);
        return en && (!slp || (sr && ext && as_m)); // R9
    endfunction

    always @(posedge clk) begin : model
        logic rise, rrst, run, stp, mt, wc, wctl;
        if (!rst_n) begin
            m_cnt <= '0; m_per <= 16'hFFFF; m_psc <= '0; m_ps <= '0;
            m_en <= 0; m_ss <= 0; m_rb <= 0; m_sr <= 0; m_as <= 0;
            m_irq <= 0; m_trig <= 0; m_wake <= 0; m_c1 <= 0; m_c2 <= 0;
        end else begin
            rise = m_c1 & ~m_c2;
            wc   = wr_en && wr_addr == 2'd0;
            wctl = wr_en && wr_addr == 2'd2;
            rrst = rise && !m_rb;
            run  = sleep_allows(m_en, m_sr, m_as, ext_clk_sel, sleep_req);
            stp  = run && tick_en && ratio_done(m_psc, m_ps);
            mt   = stp && !wc && !rrst && (m_cnt == m_per);
            if (!m_en || wc || rrst || stp) m_psc <= '0;
            else if (run && tick_en) m_psc <= m_psc + 3'd1;
            if (wc) m_cnt <= wr_data;
            else if (rrst) m_cnt <= '0;
            else if (stp) m_cnt <= (m_cnt == m_per) ? 16'd0 : m_cnt + 16'd1;
            if (wr_en && wr_addr == 2'd1) m_per <= wr_data;
            if (wctl) begin
                m_ss <= wr_data[1]; m_rb <= wr_data[2]; m_sr <= wr_data[3];
                m_as <= wr_data[4]; m_ps <= wr_data[6:5];
            end
            if (wctl) m_en <= wr_data[0];
            else if (mt && m_ss) m_en <= 1'b0;
            else if (rise && m_ss && !m_en) m_en <= 1'b1;
            if (mt) m_irq <= 1'b1;
            else if (wctl && wr_data[7]) m_irq <= 1'b0;
            m_trig <= mt && !m_as;
            m_wake <= mt && sleep_req;
            m_c1 <= cap_in;
            m_c2 <= m_c1;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            check("R2 count vs model", count_o, m_cnt);
            check("R2 period vs model", period_o, m_per);
            check("R7 enable vs model", 16'(enable_o), 16'(m_en));
            check("R4 flag vs model", 16'(irq_flag_o), 16'(m_irq));
            check("R5 trigger vs model", 16'(trig_o), 16'(m_trig));
            check("R10 wake vs model", 16'(wake_o), 16'(m_wake));
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 100000) begin
            nfail++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected<100000", cyc_n);
            summary();
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        logic [15:0] c;
        void'($urandom(32'h5EED_0123));
        cyc(4);
        rst_n = 1'b1;
        check("R1 count after reset", count_o, 16'd0);
        check("R1 period after reset", period_o, 16'hFFFF);
        check("R1 enable after reset", 16'(enable_o), 16'd0);
        check("R1 flag after reset", 16'(irq_flag_o), 16'd0);
        check("R1 trigger/wake after reset", 16'({trig_o, wake_o}), 16'd0);
        cmp_on = 1'b1;
        tick_en = 1'b1;

        // Basic period match, ratio 1, period 3.
        wr(2'd1, 16'd3);
        wr(2'd2, 16'h0001);
        cyc(3);
        check("R2 count before match", count_o, 16'd3);
        cyc(1);
        check("R2 reload to zero", count_o, 16'd0);
        check("R4 flag on match", 16'(irq_flag_o), 16'd1);
        check("R5 trigger pulse", 16'(trig_o), 16'd1);
        cyc(1);
        check("R5 trigger one cycle", 16'(trig_o), 16'd0);
        check("R4 flag sticky", 16'(irq_flag_o), 16'd1);
        wr(2'd2, 16'h0081);
        check("R4 flag cleared by write", 16'(irq_flag_o), 16'd0);

        // Prescale ratios.
        wr(2'd1, 16'd1000);
        wr(2'd2, 16'h00C1);
        wr(2'd0, 16'd0);
        cyc(8);
        check("R3 ratio 4", count_o, 16'd2);
        wr(2'd2, 16'h00E1);
        wr(2'd0, 16'd0);
        cyc(16);
        check("R3 ratio 8", count_o, 16'd2);
        wr(2'd2, 16'h00A1);
        wr(2'd0, 16'd0);
        cyc(6);
        check("R3 ratio 2", count_o, 16'd3);

        // Capture-driven reset, then blocked.
        wr(2'd2, 16'h0081);
        wr(2'd0, 16'd50);
        cyc(3);
        cap_in = 1'b1;
        cyc(2);
        check("R6 capture clears count", count_o, 16'd0);
        cap_in = 1'b0;
        cyc(2);
        wr(2'd2, 16'h0085);
        c = count_o;
        cap_in = 1'b1;
        cyc(2);
        check("R6 reset blocked", count_o, c + 16'd2);
        cap_in = 1'b0;
        cyc(2);

        // Count write coincident with capture reset.
        wr(2'd2, 16'h0081);
        cap_in = 1'b1;
        cyc(1);
        wr(2'd0, 16'd100);
        check("R8 write beats capture reset", count_o, 16'd100);
        cap_in = 1'b0;
        cyc(2);

        // One-shot delayed action.
        wr(2'd2, 16'h0082);
        wr(2'd1, 16'd5);
        wr(2'd0, 16'd0);
        check("R7 idle before capture", 16'(enable_o), 16'd0);
        cap_in = 1'b1;
        cyc(2);
        check("R7 capture starts timer", 16'(enable_o), 16'd1);
        check("R6 count cleared at start", count_o, 16'd0);
        cyc(5);
        check("R7 counting after start", count_o, 16'd5);
        cyc(1);
        check("R7 delayed trigger", 16'(trig_o), 16'd1);
        check("R7 match stops timer", 16'(enable_o), 16'd0);
        cyc(4);
        check("R7 count stays after stop", count_o, 16'd0);
        cap_in = 1'b0;
        cyc(2);

        // Sleep gating and wake.
        wr(2'd2, 16'h0081);
        wr(2'd1, 16'd1000);
        wr(2'd0, 16'd10);
        sleep_req = 1'b1;
        ext_clk_sel = 1'b0;
        c = count_o;
        cyc(5);
        check("R9 halted in sleep", count_o, c);
        ext_clk_sel = 1'b1;
        wr(2'd2, 16'h0099);
        wr(2'd0, 16'd997);
        cyc(3);
        check("R9 counting in sleep", count_o, 16'd1000);
        cyc(1);
        check("R10 wake on match", 16'(wake_o), 16'd1);
        check("R10 flag with wake", 16'(irq_flag_o), 16'd1);
        check("R5 no trigger in async mode", 16'(trig_o), 16'd0);
        cyc(1);
        check("R10 wake one cycle", 16'(wake_o), 16'd0);
        sleep_req = 1'b0;
        ext_clk_sel = 1'b0;

        // Constrained random traffic checked against the model.
        for (int i = 0; i < 6000; i++) begin
            tick_en = ($urandom_range(0, 9) < 7);
            if ($urandom_range(0, 9) == 0) cap_in = ~cap_in;
            if ($urandom_range(0, 19) == 0) sleep_req = ~sleep_req;
            if ($urandom_range(0, 29) == 0) ext_clk_sel = ~ext_clk_sel;
            wr_en = ($urandom_range(0, 19) == 0);
            wr_addr = 2'($urandom_range(0, 2));
            case (wr_addr)
                2'd0:    wr_data = 16'($urandom_range(0, 40));
                2'd1:    wr_data = 16'($urandom_range(0, 30));
                default: wr_data = 16'($urandom_range(0, 255));
            endcase
            @(negedge clk);
        end
        wr_en = 1'b0;
        cyc(2);
        summary();
        $finish;
    end

endmodule